// File: doc/BRIEF.md
# Pointer-Addressed I2C Register Target

This block is an I2C-compatible target that exposes a small bank of four 16-bit registers to a bus controller. The controller first sends a pointer byte that selects one register. Data bytes then move in either direction, with the most significant byte first. The bank holds a live temperature word, which the bus can only read. It also holds one configuration byte and two 16-bit alarm limits, a lower hysteresis limit and an upper trip limit. The alarm comparator and the fan-control logic sit outside the block and read these values from dedicated output ports.

The SCL and SDA lines are sampled into the system clock domain through a synchronizer. SDA is driven only by pulling it low. The pointer steps forward after every pair of data bytes and stops at the end of the bank; it never wraps. Two further features protect the interface. A counter watches for SDA stuck low and frees the bus when the line stays low too long. The temperature word is frozen while a read transaction is open, so that its two bytes always come from the same sample. When such a transaction closes, a one-cycle pulse tells the alarm logic that the registers have been read.

Top module: `i2crf_slave`

## Requirements
- R1: After a synchronous reset, cfg_q is 00h, hyst_q is 4B00h, thr_q is 5000h, temp_q is 0000h, sda_pull is 0 and read_done is 0.
- R2: The block acknowledges an address byte, by pulling SDA low in the ninth clock, only when bits [7:1] equal dev_addr. Bit 0 of the address byte is the direction, with 1 meaning read. For any other address it leaves SDA released until the next START.
- R3: A write to pointer 2 (hyst_q) or pointer 3 (thr_q) stores the first data byte in bits [15:8] and the second in bits [7:0]. When only one data byte is written, bits [7:0] keep their previous value.
- R4: Pointer 1 selects the 8-bit configuration register. Every data byte written there replaces it, so the last byte of a pair is the one kept. A read of it returns the same byte in both halves.
- R5: The pointer advances after every second data byte, in reads and in writes. Only bits [1:0] of the pointer byte are used. Once the pointer has moved past 3, it stays past the end: further writes are acknowledged and discarded, and reads return FFh.
- R6: A read is performed as: address with the write bit, pointer byte, repeated START, address with the read bit, then data bytes MSB first. Pointer 0 returns the temperature word taken from temp_in.
- R7: Writes aimed at pointer 0 are acknowledged and discarded. While a read transaction is open, from the read-address acknowledge until the STOP, temp_q holds its value whatever temp_in does.
- R8: When cfg_q[6] is 0 and SDA stays low for TIMEOUT_CYC consecutive clocks, the interface returns to idle and releases SDA. When cfg_q[6] is 1, no such release happens.
- R9: read_done pulses high for exactly one clock at a STOP that ends a transaction containing a read address phase. A transaction made only of writes produces no pulse.
- R10: After the controller does not acknowledge a read byte, the block releases SDA and drives nothing until the next START.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| dev_addr | input | 7 | Bus address of this target |
| temp_in | input | 16 | Live temperature word from the converter |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| temp_q | output | 16 | Temperature register contents |
| cfg_q | output | 8 | Configuration register contents |
| hyst_q | output | 16 | Hysteresis limit register contents |
| thr_q | output | 16 | Trip limit register contents |
| read_done | output | 1 | One-clock pulse at the STOP ending a read transaction |

## Verification
The bench builds the block with TIMEOUT_CYC set to 1500 clocks, in place of the multi-million default. This puts the stuck-SDA release in both configurations, enabled and disabled, within a short run. With that value, several consecutive all-zero bytes in normal traffic still stay well clear of the limit, so ordinary transfers never trip the timeout by accident. The synchronizer keeps its default of two stages, and a bus quarter-period of eight clocks leaves room for every internal reaction to settle between SCL edges.

// File: rtl/i2crf_pkg.sv
package i2crf_pkg;

    localparam int REG_W  = 16;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    localparam logic [1:0] IDX_TEMP = 2'd0;
    localparam logic [1:0] IDX_CFG  = 2'd1;
    localparam logic [1:0] IDX_HYST = 2'd2;
    localparam logic [1:0] IDX_THR  = 2'd3;

    localparam logic [2:0] PTR_END = 3'd4;

    localparam logic [BYTE_W-1:0] RST_CFG  = 8'h00;
    localparam logic [REG_W-1:0]  RST_TEMP = 16'h0000;
    localparam logic [REG_W-1:0]  RST_HYST = 16'h4B00;
    localparam logic [REG_W-1:0]  RST_THR  = 16'h5000;

    localparam int CFG_TMO_OFF = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACKTX,
        ST_TX,
        ST_ACKRX
    } eng_st_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_PTR,
        K_DATA
    } byte_kind_e;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic [2:0] ptr_step(input logic [2:0] p);
        return (p >= PTR_END) ? PTR_END : p + 3'd1;
    endfunction

    function automatic logic [REG_W-1:0] limit_reset(input int n);
        return (n == 0) ? RST_HYST : RST_THR;
    endfunction

endpackage

// File: rtl/i2crf_cond.sv
module i2crf_cond
    import i2crf_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [STAGES-1:0] scl_p, sda_p;
    logic              scl_d, sda_d;
    logic              scl_n, sda_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_i};
            sda_p <= {sda_p[STAGES-2:0], sda_i};
            scl_d <= scl_p[STAGES-1];
            sda_d <= sda_p[STAGES-1];
        end
    end

    assign scl_n = scl_p[STAGES-1];
    assign sda_n = sda_p[STAGES-1];

    always_comb begin
        ev.sda      = sda_n;
        ev.scl_rise = scl_n & ~scl_d;
        ev.scl_fall = ~scl_n & scl_d;
        ev.start    = scl_n & scl_d & sda_d & ~sda_n;
        ev.stop     = scl_n & scl_d & ~sda_d & sda_n;
    end

endmodule

// File: rtl/i2crf_lockup.sv
module i2crf_lockup #(
    parameter int TIMEOUT_CYC = 2_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic sda_s,
    output logic fire
);

    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (!enable || sda_s) begin
                cnt_q <= '0;
            end else if (cnt_q == LAST) begin
                cnt_q <= '0;
                fire  <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R8: a release only follows a low, enabled line
    a_r8_fire_after_low: assert property (@(posedge clk) disable iff (rst)
        fire |-> $past(!sda_s && enable));

    a_r8_fire_single: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

endmodule

// File: rtl/i2crf_regbank.sv
module i2crf_regbank
    import i2crf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              ptr_wr,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              rd_adv,
    input  logic              rd_hold,
    input  logic [REG_W-1:0]  temp_in,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [REG_W-1:0]  temp_q,
    output logic [BYTE_W-1:0] cfg_q,
    output logic [REG_W-1:0]  hyst_q,
    output logic [REG_W-1:0]  thr_q
);

    logic [2:0]       ptr_q;
    logic             half_q;
    logic             in_range;
    logic [1:0]       idx;
    logic [REG_W-1:0] lim_q [2];
    logic [REG_W-1:0] word;

    assign in_range = ~ptr_q[2];
    assign idx      = ptr_q[1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            half_q <= 1'b0;
        end else if (ptr_wr) begin
            ptr_q  <= {1'b0, wr_byte[1:0]};
            half_q <= 1'b0;
        end else if (start_i) begin
            half_q <= 1'b0;
        end else if (data_wr || rd_adv) begin
            if (half_q) begin
                half_q <= 1'b0;
                ptr_q  <= ptr_step(ptr_q);
            end else begin
                half_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= RST_CFG;
        else if (data_wr && in_range && idx == IDX_CFG)
            cfg_q <= wr_byte;
    end

    always_ff @(posedge clk) begin
        if (rst)
            temp_q <= RST_TEMP;
        else if (!rd_hold)
            temp_q <= temp_in;
    end

    for (genvar g = 0; g < 2; g++) begin : g_lim
        localparam logic [1:0]       MY_IDX = 2'(32'(IDX_HYST) + g);
        localparam logic [REG_W-1:0] RV     = limit_reset(g);
        logic [REG_W-1:0] r_q;
        always_ff @(posedge clk) begin
            if (rst)
                r_q <= RV;
            else if (data_wr && in_range && idx == MY_IDX) begin
                if (half_q)
                    r_q[BYTE_W-1:0] <= wr_byte;
                else
                    r_q[REG_W-1:BYTE_W] <= wr_byte;
            end
        end
        assign lim_q[g] = r_q;
    end

    assign hyst_q = lim_q[0];
    assign thr_q  = lim_q[1];

    always_comb begin
        case (idx)
            IDX_TEMP: word = temp_q;
            IDX_CFG:  word = {cfg_q, cfg_q};
            IDX_HYST: word = lim_q[0];
            default:  word = lim_q[1];
        endcase
        if (!in_range)
            rd_byte = 8'hFF;
        else if (half_q)
            rd_byte = word[BYTE_W-1:0];
        else
            rd_byte = word[REG_W-1:BYTE_W];
    end

    a_r5_ptr_bounded: assert property (@(posedge clk) disable iff (rst)
        ptr_q <= PTR_END);

    // R5: data past the end of the bank changes nothing
    a_r5_past_end_discard: assert property (@(posedge clk) disable iff (rst)
        (data_wr && ptr_q[2]) |=> ($stable(cfg_q) && $stable(hyst_q) && $stable(thr_q)));

    a_r7_temp_frozen: assert property (@(posedge clk) disable iff (rst)
        rd_hold |=> $stable(temp_q));

endmodule

// File: rtl/i2crf_engine.sv
module i2crf_engine
    import i2crf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              bus_reset,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_drv,
    output logic              ptr_wr,
    output logic              data_wr,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              rd_adv,
    output logic              rd_busy,
    output logic              read_done
);

    eng_st_e     st_q;
    byte_kind_e  kind_q;
    logic [3:0]  bit_q;
    logic [7:0]  sh_q;
    logic        dir_rd_q;
    logic        mack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            kind_q    <= K_ADDR;
            bit_q     <= '0;
            sh_q      <= '0;
            dir_rd_q  <= 1'b0;
            mack_q    <= 1'b0;
            sda_drv   <= 1'b0;
            ptr_wr    <= 1'b0;
            data_wr   <= 1'b0;
            rd_adv    <= 1'b0;
            rd_busy   <= 1'b0;
            read_done <= 1'b0;
        end else begin
            ptr_wr    <= 1'b0;
            data_wr   <= 1'b0;
            rd_adv    <= 1'b0;
            read_done <= 1'b0;
            if (bus_reset) begin
                st_q    <= ST_IDLE;
                sda_drv <= 1'b0;
                rd_busy <= 1'b0;
            end else if (ev.stop) begin
                st_q      <= ST_IDLE;
                sda_drv   <= 1'b0;
                read_done <= rd_busy;
                rd_busy   <= 1'b0;
            end else if (ev.start) begin
                st_q    <= ST_RX;
                kind_q  <= K_ADDR;
                bit_q   <= '0;
                sda_drv <= 1'b0;
            end else begin
                case (st_q)
                    ST_RX: begin
                        if (ev.scl_rise && bit_q != 4'd8) begin
                            sh_q  <= {sh_q[6:0], ev.sda};
                            bit_q <= bit_q + 4'd1;
                        end else if (ev.scl_fall && bit_q == 4'd8) begin
                            case (kind_q)
                                K_ADDR: begin
                                    if (sh_q[7:1] == dev_addr) begin
                                        sda_drv  <= 1'b1;
                                        st_q     <= ST_ACKTX;
                                        dir_rd_q <= sh_q[0];
                                        if (sh_q[0])
                                            rd_busy <= 1'b1;
                                    end else begin
                                        st_q <= ST_IDLE;
                                    end
                                end
                                K_PTR: begin
                                    ptr_wr  <= 1'b1;
                                    sda_drv <= 1'b1;
                                    st_q    <= ST_ACKTX;
                                end
                                default: begin
                                    data_wr <= 1'b1;
                                    sda_drv <= 1'b1;
                                    st_q    <= ST_ACKTX;
                                end
                            endcase
                        end
                    end
                    ST_ACKTX: begin
                        if (ev.scl_fall) begin
                            bit_q <= '0;
                            if (kind_q == K_ADDR && dir_rd_q) begin
                                sh_q    <= rd_byte;
                                sda_drv <= ~rd_byte[7];
                                rd_adv  <= 1'b1;
                                st_q    <= ST_TX;
                            end else begin
                                sda_drv <= 1'b0;
                                st_q    <= ST_RX;
                                kind_q  <= (kind_q == K_ADDR) ? K_PTR : K_DATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_fall) begin
                            if (bit_q == 4'd7) begin
                                sda_drv <= 1'b0;
                                st_q    <= ST_ACKRX;
                            end else begin
                                sh_q    <= {sh_q[6:0], 1'b0};
                                sda_drv <= ~sh_q[6];
                                bit_q   <= bit_q + 4'd1;
                            end
                        end
                    end
                    ST_ACKRX: begin
                        if (ev.scl_rise) begin
                            mack_q <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (mack_q) begin
                                sh_q    <= rd_byte;
                                sda_drv <= ~rd_byte[7];
                                rd_adv  <= 1'b1;
                                bit_q   <= '0;
                                st_q    <= ST_TX;
                            end else begin
                                st_q <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign wr_byte = sh_q;

    a_r10_idle_released: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |-> !sda_drv);

    a_r8_release_on_timeout: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> !sda_drv);

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        read_done |=> !read_done);

    // R6: data is only shifted out after a read address
    a_r6_tx_needs_read: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_TX) |-> dir_rd_q);

endmodule

// File: rtl/i2crf_slave.sv
module i2crf_slave
    import i2crf_pkg::*;
#(
    parameter int TIMEOUT_CYC = 2_500_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [REG_W-1:0]  temp_in,
    output logic              sda_pull,
    output logic [REG_W-1:0]  temp_q,
    output logic [BYTE_W-1:0] cfg_q,
    output logic [REG_W-1:0]  hyst_q,
    output logic [REG_W-1:0]  thr_q,
    output logic              read_done
);

    bus_ev_t           ev;
    logic              bus_reset;
    logic              ptr_wr, data_wr, rd_adv, rd_busy;
    logic [BYTE_W-1:0] wr_byte, rd_byte;

    i2crf_cond #(.STAGES(SYNC_STAGES)) u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2crf_lockup #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_lockup (
        .clk    (clk),
        .rst    (rst),
        .enable (~cfg_q[CFG_TMO_OFF]),
        .sda_s  (ev.sda),
        .fire   (bus_reset)
    );

    i2crf_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .dev_addr  (dev_addr),
        .bus_reset (bus_reset),
        .rd_byte   (rd_byte),
        .sda_drv   (sda_pull),
        .ptr_wr    (ptr_wr),
        .data_wr   (data_wr),
        .wr_byte   (wr_byte),
        .rd_adv    (rd_adv),
        .rd_busy   (rd_busy),
        .read_done (read_done)
    );

    i2crf_regbank u_regs (
        .clk     (clk),
        .rst     (rst),
        .start_i (ev.start),
        .ptr_wr  (ptr_wr),
        .data_wr (data_wr),
        .wr_byte (wr_byte),
        .rd_adv  (rd_adv),
        .rd_hold (rd_busy),
        .temp_in (temp_in),
        .rd_byte (rd_byte),
        .temp_q  (temp_q),
        .cfg_q   (cfg_q),
        .hyst_q  (hyst_q),
        .thr_q   (thr_q)
    );

endmodule

// File: tb/sim_i2crf_slave.sv
module sim_i2crf_slave;

    localparam int TMO = 1500;
    localparam int Q   = 8;
    localparam logic [6:0] DEV = 7'h48;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_line;
    logic [15:0] temp_in = 16'h0000;
    logic        sda_pull, read_done;
    logic [15:0] temp_q, hyst_q, thr_q;
    logic [7:0]  cfg_q;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    i2crf_slave #(.TIMEOUT_CYC(TMO)) u0 (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .dev_addr  (DEV),
        .temp_in   (temp_in),
        .sda_pull  (sda_pull),
        .temp_q    (temp_q),
        .cfg_q     (cfg_q),
        .hyst_q    (hyst_q),
        .thr_q     (thr_q),
        .read_done (read_done)
    );

    always @(posedge clk) if (read_done) done_cnt <= done_cnt + 1;

    task automatic check(input string req, input string what,
                         input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wq(input int n = 1);
        repeat (n * Q) @(posedge clk);
        #1;
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic wbit(input logic b);
        m_sda = b;    wq();
        m_scl = 1'b1; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic rbit(output logic b);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        b = sda_line;
        m_scl = 1'b0; wq();
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(b);
        ack = ~b;
    endtask

    task automatic rbyte(output logic [7:0] d, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            d[i] = b;
        end
        wbit(~give_ack);
    endtask

    task automatic write_regs(input logic [7:0] ptr, input logic [31:0] data, input int n);
        logic ack;
        i2c_start();
        wbyte({DEV, 1'b0}, ack);
        wbyte(ptr, ack);
        for (int i = 0; i < n; i++) wbyte(data[31-8*i -: 8], ack);
        i2c_stop();
    endtask

    task automatic read_regs(input logic [7:0] ptr, input int n, output logic [47:0] got);
        logic       ack;
        logic [7:0] b;
        got = '0;
        i2c_start();
        wbyte({DEV, 1'b0}, ack);
        wbyte(ptr, ack);
        i2c_start();
        wbyte({DEV, 1'b1}, ack);
        for (int i = 0; i < n; i++) begin
            rbyte(b, i != n - 1);
            got = {got[39:0], b};
        end
        i2c_stop();
    endtask

    task automatic t_reset();
        check("R1", "cfg", 48'(cfg_q), 48'h00);
        check("R1", "hyst", 48'(hyst_q), 48'h4B00);
        check("R1", "thr", 48'(thr_q), 48'h5000);
        check("R1", "temp", 48'(temp_q), 48'h0000);
        check("R1", "sda_pull", 48'(sda_pull), 48'h0);
        check("R1", "read_done", 48'(read_done), 48'h0);
    endtask

    task automatic t_addr();
        logic ack;
        i2c_start();
        wbyte({7'h23, 1'b0}, ack);
        check("R2", "foreign address ack", 48'(ack), 48'h0);
        wbyte(8'h00, ack);
        check("R2", "no drive after mismatch", 48'(ack), 48'h0);
        i2c_stop();
        i2c_start();
        wbyte({DEV, 1'b0}, ack);
        check("R2", "own address ack", 48'(ack), 48'h1);
        i2c_stop();
    endtask

    task automatic t_write16();
        write_regs(8'h03, 32'h1234_0000, 2);
        check("R3", "thr two bytes", 48'(thr_q), 48'h1234);
        write_regs(8'h02, 32'h4B55_0000, 2);
        write_regs(8'h02, 32'hAB00_0000, 1);
        check("R3", "hyst single byte", 48'(hyst_q), 48'hAB55);
    endtask

    task automatic t_cfg();
        logic [47:0] got;
        write_regs(8'h01, 32'h1122_0000, 2);
        check("R4", "cfg second byte kept", 48'(cfg_q), 48'h22);
        read_regs(8'h01, 2, got);
        check("R4", "cfg mirrored read", got, 48'h2222);
    endtask

    task automatic t_autoinc();
        logic [47:0] got;
        write_regs(8'h02, 32'h0102_0304, 4);
        check("R5", "hyst via increment", 48'(hyst_q), 48'h0102);
        check("R5", "thr via increment", 48'(thr_q), 48'h0304);
        write_regs(8'h03, 32'hAABB_CCDD, 4);
        check("R5", "thr before end", 48'(thr_q), 48'hAABB);
        check("R5", "hyst no wrap", 48'(hyst_q), 48'h0102);
        check("R5", "cfg no wrap", 48'(cfg_q), 48'h22);
        read_regs(8'h02, 6, got);
        check("R5", "read past end", got, 48'h0102_AABB_FFFF);
        write_regs(8'h00, 32'h7766_0500, 3);
        check("R7", "temp write discarded, next is cfg", 48'(cfg_q), 48'h05);
        check("R7", "temp follows input", 48'(temp_q), 48'(temp_in));
    endtask

    task automatic t_temp();
        logic [47:0] got;
        logic [7:0]  b0, b1;
        logic        ack;
        temp_in = 16'h1900;
        wq();
        read_regs(8'h00, 2, got);
        check("R6", "temp read", got, 48'h1900);
        i2c_start();
        wbyte({DEV, 1'b0}, ack);
        wbyte(8'h00, ack);
        i2c_start();
        wbyte({DEV, 1'b1}, ack);
        rbyte(b0, 1'b1);
        temp_in = 16'hE700;
        wq(2);
        rbyte(b1, 1'b0);
        check("R7", "temp_q frozen during read", 48'(temp_q), 48'h1900);
        i2c_stop();
        check("R7", "bytes from one sample", 48'({b0, b1}), 48'h1900);
        check("R7", "temp_q resumes", 48'(temp_q), 48'hE700);
        read_regs(8'h00, 2, got);
        check("R6", "new temp read", got, 48'hE700);
    endtask

    task automatic t_done();
        int          c0;
        logic [47:0] got;
        c0 = done_cnt;
        write_regs(8'h03, 32'h5000_0000, 2);
        check("R9", "no pulse for write", 48'(done_cnt - c0), 48'h0);
        read_regs(8'h01, 1, got);
        check("R9", "one pulse for read", 48'(done_cnt - c0), 48'h1);
    endtask

    task automatic t_nack();
        logic       ack;
        logic [7:0] b;
        i2c_start();
        wbyte({DEV, 1'b0}, ack);
        wbyte(8'h02, ack);
        i2c_start();
        wbyte({DEV, 1'b1}, ack);
        rbyte(b, 1'b0);
        check("R10", "byte before nack", 48'(b), 48'h01);
        rbyte(b, 1'b1);
        check("R10", "released after nack", 48'(b), 48'hFF);
        check("R10", "sda_pull idle", 48'(sda_pull), 48'h0);
        i2c_stop();
    endtask

    task automatic stall_at_ack();
        logic [7:0] a;
        a = {DEV, 1'b0};
        i2c_start();
        for (int i = 7; i >= 0; i--) wbit(a[i]);
        m_sda = 1'b1;
        wq();
    endtask

    task automatic t_timeout();
        stall_at_ack();
        check("R8", "ack held", 48'(sda_pull), 48'h1);
        repeat (1000) @(posedge clk);
        #1;
        check("R8", "still held before limit", 48'(sda_pull), 48'h1);
        repeat (700) @(posedge clk);
        #1;
        check("R8", "released after limit", 48'(sda_pull), 48'h0);
        i2c_stop();
        write_regs(8'h01, 32'h4000_0000, 1);
        check("R8", "timeout disabled cfg", 48'(cfg_q), 48'h40);
        stall_at_ack();
        repeat (1800) @(posedge clk);
        #1;
        check("R8", "held with timeout off", 48'(sda_pull), 48'h1);
        m_scl = 1'b1; wq();
        m_scl = 1'b0; wq();
        i2c_stop();
        write_regs(8'h01, 32'h0000_0000, 1);
        check("R8", "cfg restored", 48'(cfg_q), 48'h00);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        wq();
        t_reset();
        t_addr();
        t_write16();
        t_cfg();
        t_autoinc();
        t_temp();
        t_done();
        t_nack();
        t_timeout();
        finish_run();
    end

endmodule